// File: doc/BRIEF.md
# Chroma Subsampling Stage for Writeback

This block sits behind the colour converter on a writeback path. It takes a stream of full-resolution YCbCr pixels and reduces the chroma to 4:2:2 or 4:2:0 before the pixels reach the memory writer. Luma passes through at full rate. Each output beat carries a chroma-valid flag, so the packer downstream can tell full beats from luma-only beats.

A small set of configuration inputs is programmed before each frame: an enable, a layout code, an output depth bit, and the frame width and height. The layout code implies the horizontal and vertical filter methods. Horizontal decimation is co-sited: the chroma of each even column is kept after a three-tap [1 2 1] filter, rounded by adding 2 before the divide by 4. At a line end the edge sample is repeated. Vertical decimation is off-site: the filtered chroma of an even line is held in a line buffer and averaged with the next odd line, rounding half up. With the enable low the block is bypassed completely.

The input and output are valid/ready streams. The input carries a start-of-frame marker. The output carries start-of-frame, plus an end-of-line marker derived from the programmed width.

Top module: `chroma_decimator`

## Requirements
- R1: After reset, with the enable high, out_valid is 0 and in_ready is 1.
- R2: Layout code 0 (no subsampling) gives one output beat per input pixel, with out_cvalid = 1 and the pixel's own Cb and Cr.
- R3: Layout code 1 (4:2:2) sets out_cvalid only at even column indices. The chroma there is (left + 2·centre + right + 2) >> 2 of the input chroma, where a missing left or right neighbour at a line edge is replaced by the centre sample.
- R4: Layout code 2 (4:2:0) sets out_cvalid only at even columns of odd line indices. The chroma there is (F_prev + F_cur + 1) >> 1, where F is the R3 filter value of the same column on the line above and on the current line.
- R5: In layout code 2, when the programmed height is odd, the last line (an even line) carries chroma at even columns, equal to its own R3 filter value.
- R6: Layout code 3 (vertical-only, unsupported) behaves exactly as layout code 0.
- R7: With cfg_depth10 = 0, every output component equals min((v + 2) >> 2, 255) of its 10-bit value, placed in bits 7:0 with the upper bits zero. With cfg_depth10 = 1, values are passed at full width.
- R8: With cfg_en = 0, the outputs follow the inputs combinationally. Luma and chroma are raw, out_cvalid is 1, and in_ready equals out_ready.
- R9: Every accepted pixel yields exactly one output beat, in order, with full-rate luma. out_sof marks column 0 of line 0, and out_eol marks column cfg_width − 1.
- R10: While out_valid is high and out_ready is low, out_valid and all output data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | 1 = process, 0 = bypass |
| cfg_layout | input | 2 | 0 none, 1 4:2:2, 2 4:2:0, 3 vertical-only (falls back to none) |
| cfg_depth10 | input | 1 | 1 = 10-bit output, 0 = 8-bit output |
| cfg_width | input | $clog2(MAX_W+1) | Pixels per line |
| cfg_height | input | $clog2(MAX_H+1) | Lines per frame |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_sof | input | 1 | First pixel of a frame |
| in_y | input | DATA_W | Luma |
| in_cb | input | DATA_W | Blue-difference chroma |
| in_cr | input | DATA_W | Red-difference chroma |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_sof | output | 1 | Beat is column 0 of line 0 |
| out_eol | output | 1 | Beat is the last column of a line |
| out_cvalid | output | 1 | Beat carries chroma |
| out_y | output | DATA_W | Luma |
| out_cb | output | DATA_W | Cb when out_cvalid |
| out_cr | output | DATA_W | Cr when out_cvalid |

## Verification
A wrong column or line parity in the held pixel shows at once. Chroma-valid appears on the wrong beat, or out_eol misses the programmed width, on the first line of the first frame. A wrong line buffer entry or filter neighbour corrupts the chroma of the first odd line in 4:2:0 mode, one line after the fault. A broken flush at the line end loses or duplicates a beat, which breaks the beat order within that line. The sweep therefore covers widths of one, two, odd and even, heights of one to three, every layout code at both depths, and random backpressure.

// File: rtl/cds_pkg.sv
package cds_pkg;
   typedef enum logic [1:0] {
      LAY_NONE  = 2'd0,
      LAY_H2    = 2'd1,
      LAY_H2V2  = 2'd2,
      LAY_V2    = 2'd3
   } layout_e;

   localparam int NUM_CHROMA = 2;
endpackage

// File: rtl/cds_hfilt.sv
// Three-tap [1 2 1] chroma filter, rounded.
module cds_hfilt #(
   parameter int W = 10
) (
   input  logic [W-1:0] left,
   input  logic [W-1:0] mid,
   input  logic [W-1:0] right,
   output logic [W-1:0] filt
);
   assign filt = W'(({2'b00, left} + {1'b0, mid, 1'b0} + {2'b00, right} + (W+2)'(2)) >> 2);
endmodule

// File: rtl/cds_linebuf.sv
// Holds the filtered chroma of the last even line, one entry per chroma pair.
module cds_linebuf #(
   parameter int W  = 20,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cds_depth.sv
// Output depth stage: full width, or rounded and saturated to 8 bits.
module cds_depth #(
   parameter int W = 10
) (
   input  logic [W-1:0] din,
   input  logic         keep,
   output logic [W-1:0] dout
);
   localparam logic [W-1:0] MAX8 = W'(255);

   logic [W-1:0] q;

   assign q    = W'(({2'b00, din} + (W+2)'(2)) >> 2);
   assign dout = keep ? din : ((q > MAX8) ? MAX8 : q);
endmodule

// File: rtl/chroma_decimator.sv
module chroma_decimator
   import cds_pkg::*;
#(
   parameter  int DATA_W = 10,
   parameter  int MAX_W  = 64,
   parameter  int MAX_H  = 64,
   localparam int WW     = $clog2(MAX_W + 1),
   localparam int HW     = $clog2(MAX_H + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [1:0]        cfg_layout,
   input  logic              cfg_depth10,
   input  logic [WW-1:0]     cfg_width,
   input  logic [HW-1:0]     cfg_height,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_sof,
   input  logic [DATA_W-1:0] in_y,
   input  logic [DATA_W-1:0] in_cb,
   input  logic [DATA_W-1:0] in_cr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_sof,
   output logic              out_eol,
   output logic              out_cvalid,
   output logic [DATA_W-1:0] out_y,
   output logic [DATA_W-1:0] out_cb,
   output logic [DATA_W-1:0] out_cr
);
   localparam int AW = WW - 1;
   localparam int NC = NUM_CHROMA;

   if (DATA_W < 10) begin : g_bad_dw
      $error("chroma_decimator: DATA_W must be at least 10");
   end
   if (MAX_W < 2 || (MAX_W % 2) != 0) begin : g_bad_w
      $error("chroma_decimator: MAX_W must be even and at least 2");
   end
   if (MAX_H < 1) begin : g_bad_h
      $error("chroma_decimator: MAX_H must be at least 1");
   end

   // mode decode
   layout_e lay;
   logic    h_on, v_on;
   assign lay  = layout_e'(cfg_layout);
   assign h_on = (lay == LAY_H2) || (lay == LAY_H2V2);
   assign v_on = (lay == LAY_H2V2);

   // position of the incoming pixel
   logic [WW-1:0] x_cnt, xi;
   logic [HW-1:0] l_cnt, li;
   logic          in_last, acc;

   assign xi      = in_sof ? '0 : x_cnt;
   assign li      = in_sof ? '0 : l_cnt;
   assign in_last = (xi == cfg_width - WW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_cnt <= '0;
         l_cnt <= '0;
      end else if (acc) begin
         if (in_last) begin
            x_cnt <= '0;
            l_cnt <= li + HW'(1);
         end else begin
            x_cnt <= xi + WW'(1);
            l_cnt <= li;
         end
      end
   end

   // held pixel: output one pixel behind the input, flushed at line end
   logic [DATA_W-1:0] in_c [NC];
   logic [DATA_W-1:0] p_c  [NC];
   logic [DATA_W-1:0] l_c  [NC];
   logic [DATA_W-1:0] r_c  [NC];
   logic [DATA_W-1:0] hf   [NC];
   logic [DATA_W-1:0] abv  [NC];
   logic [DATA_W-1:0] avg  [NC];
   logic [DATA_W-1:0] sel  [NC];
   logic [DATA_W-1:0] dep  [NC];
   logic [DATA_W-1:0] p_y, y_dep;
   logic [AW-1:0]     p_xh;
   logic              pv, p_sof, p_last, p_even, p_lodd, p_llast;
   logic              en_ovalid, en_iready, fire_o, cval;

   assign in_c[0] = in_cb;
   assign in_c[1] = in_cr;

   assign en_ovalid = pv && (p_last || in_valid);
   assign en_iready = !pv || (!p_last && out_ready);
   assign in_ready  = cfg_en ? en_iready : out_ready;
   assign out_valid = cfg_en ? en_ovalid : in_valid;
   assign acc       = in_valid && in_ready;
   assign fire_o    = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv      <= 1'b0;
         p_y     <= '0;
         p_sof   <= 1'b0;
         p_last  <= 1'b0;
         p_even  <= 1'b0;
         p_lodd  <= 1'b0;
         p_llast <= 1'b0;
         p_xh    <= '0;
         for (int k = 0; k < NC; k++) begin
            p_c[k] <= '0;
            l_c[k] <= '0;
         end
      end else if (!cfg_en) begin
         pv <= 1'b0;
      end else if (acc) begin
         pv      <= 1'b1;
         p_y     <= in_y;
         p_sof   <= in_sof;
         p_last  <= in_last;
         p_even  <= !xi[0];
         p_lodd  <= li[0];
         p_llast <= (li == cfg_height - HW'(1));
         p_xh    <= AW'(xi >> 1);
         for (int k = 0; k < NC; k++) begin
            p_c[k] <= in_c[k];
            l_c[k] <= (xi == '0) ? in_c[k] : p_c[k];
         end
      end else if (fire_o) begin
         pv <= 1'b0;
      end
   end

   // line buffer of filtered even-line chroma
   logic                wr_buf;
   logic [2*DATA_W-1:0] buf_rd;

   assign wr_buf = fire_o && cfg_en && v_on && p_even && !p_lodd;

   cds_linebuf #(.W(2*DATA_W), .AW(AW)) u_lbuf (
      .clk   (clk),
      .we    (wr_buf),
      .waddr (p_xh),
      .wdata ({hf[1], hf[0]}),
      .raddr (p_xh),
      .rdata (buf_rd)
   );

   assign abv[0] = buf_rd[DATA_W-1:0];
   assign abv[1] = buf_rd[2*DATA_W-1:DATA_W];

   assign cval = !h_on ? 1'b1
               : !v_on ? p_even
               : (p_even && (p_lodd || p_llast));

   for (genvar k = 0; k < NC; k++) begin : g_chroma
      assign r_c[k] = p_last ? p_c[k] : in_c[k];

      cds_hfilt #(.W(DATA_W)) u_hf (
         .left  (l_c[k]),
         .mid   (p_c[k]),
         .right (r_c[k]),
         .filt  (hf[k])
      );

      assign avg[k] = DATA_W'(({1'b0, abv[k]} + {1'b0, hf[k]} + (DATA_W+1)'(1)) >> 1);
      assign sel[k] = !h_on ? p_c[k] : ((v_on && p_lodd) ? avg[k] : hf[k]);

      cds_depth #(.W(DATA_W)) u_dep (
         .din  (sel[k]),
         .keep (cfg_depth10),
         .dout (dep[k])
      );
   end

   cds_depth #(.W(DATA_W)) u_ydep (
      .din  (p_y),
      .keep (cfg_depth10),
      .dout (y_dep)
   );

   assign out_sof    = cfg_en ? p_sof  : in_sof;
   assign out_eol    = cfg_en ? p_last : in_last;
   assign out_cvalid = cfg_en ? cval   : 1'b1;
   assign out_y      = cfg_en ? y_dep  : in_y;
   assign out_cb     = cfg_en ? dep[0] : in_cb;
   assign out_cr     = cfg_en ? dep[1] : in_cr;
endmodule

// File: rtl/chroma_decimator_chk.sv
module chroma_decimator_chk #(
   parameter int DATA_W = 10,
   parameter int WW     = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic [1:0]        cfg_layout,
   input logic              cfg_depth10,
   input logic [WW-1:0]     cfg_width,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_sof,
   input logic              out_eol,
   input logic              out_cvalid,
   input logic [DATA_W-1:0] out_y,
   input logic [DATA_W-1:0] out_cb,
   input logic [DATA_W-1:0] out_cr
);
   // independent column count of output beats
   logic [WW-1:0] col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) col <= '0;
      else if (out_valid && out_ready) col <= out_eol ? '0 : col + WW'(1);
   end

   logic subs, passm;
   assign subs  = cfg_en && (cfg_layout == 2'd1 || cfg_layout == 2'd2);
   assign passm = cfg_en && (cfg_layout == 2'd0 || cfg_layout == 2'd3);

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
      out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_cb)
                                  && $stable(out_cr) && $stable(out_cvalid)); // R10

   AST_ODD_LUMA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && subs && col[0] |-> !out_cvalid); // R3

   AST_PASS_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && passm |-> out_cvalid); // R6

   AST_EOL_AT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_eol |-> col == cfg_width - WW'(1)); // R9

   AST_SOF_AT_COL0: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sof |-> col == '0); // R9

   AST_DEPTH8_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && cfg_en && !cfg_depth10 |->
         (out_y <= DATA_W'(255)) && (!out_cvalid || (out_cb <= DATA_W'(255) && out_cr <= DATA_W'(255)))); // R7
endmodule

bind chroma_decimator chroma_decimator_chk #(.DATA_W(DATA_W), .WW(WW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_en      (cfg_en),
   .cfg_layout  (cfg_layout),
   .cfg_depth10 (cfg_depth10),
   .cfg_width   (cfg_width),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_sof     (out_sof),
   .out_eol     (out_eol),
   .out_cvalid  (out_cvalid),
   .out_y       (out_y),
   .out_cb      (out_cb),
   .out_cr      (out_cr)
);

// File: tb/tb_chroma_decimator.sv
`timescale 1ns/1ps
module tb_chroma_decimator;
   localparam int DW = 10;
   localparam int MW = 64;
   localparam int MH = 64;
   localparam int WW = $clog2(MW + 1);
   localparam int HW = $clog2(MH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b1;
   logic [1:0]    cfg_layout = 2'd0;
   logic          cfg_depth10 = 1'b1;
   logic [WW-1:0] cfg_width = WW'(4);
   logic [HW-1:0] cfg_height = HW'(2);
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic          in_sof = 1'b0;
   logic [DW-1:0] in_y = '0, in_cb = '0, in_cr = '0;
   logic          out_valid, out_ready = 1'b0;
   logic          out_sof, out_eol, out_cvalid;
   logic [DW-1:0] out_y, out_cb, out_cr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   chroma_decimator #(.DATA_W(DW), .MAX_W(MW), .MAX_H(MH)) dut (.*);

   function automatic int pix(int l, int x, int c, int seed);
      if (c == 0) return (l == 0 && x == 1) ? 1023 : (l*37 + x*53 + seed*11) % 1024;
      if (c == 1) return (l == 1 && x == 0) ? 1022 : (l*91 + x*29 + seed*3 + 500) % 1024;
      return 1023 - ((l*67 + x*113 + seed*5) % 1024);
   endfunction

   function automatic int conv(int v, bit d10);
      int q;
      if (d10) return v;
      q = (v + 2) >> 2;
      return (q > 255) ? 255 : q;
   endfunction

   function automatic int hf(int l, int x, int c, int w, int seed);
      int xl, xr;
      xl = (x == 0) ? 0 : x - 1;
      xr = (x == w - 1) ? x : x + 1;
      return (pix(l, xl, c, seed) + 2*pix(l, x, c, seed) + pix(l, xr, c, seed) + 2) >> 2;
   endfunction

   task automatic check_beat(bit en, int lay, bit d10, int w, int h, int seed, int l, int x);
      int ey, ecb, ecr;
      bit ecv, esof, eeol;
      string tg, ty;
      esof = (l == 0 && x == 0);
      eeol = (x == w - 1);
      ey   = en ? conv(pix(l, x, 0, seed), d10) : pix(l, x, 0, seed);
      ty   = (en && !d10) ? "R7" : (en ? "R9" : "R8");
      checks++;
      if (out_y != DW'(ey) || out_sof != esof || out_eol != eeol) begin
         errors++;
         $display("FAIL %s luma/markers l=%0d x=%0d got y=%0d sof=%0b eol=%0b exp y=%0d sof=%0b eol=%0b",
                  ty, l, x, out_y, out_sof, out_eol, ey, esof, eeol);
      end
      if (!en) begin
         tg = "R8"; ecv = 1; ecb = pix(l, x, 1, seed); ecr = pix(l, x, 2, seed);
      end else if (lay == 0 || lay == 3) begin
         tg = (lay == 0) ? "R2" : "R6"; ecv = 1;
         ecb = conv(pix(l, x, 1, seed), d10); ecr = conv(pix(l, x, 2, seed), d10);
      end else if (lay == 1) begin
         tg = "R3"; ecv = (x % 2 == 0);
         ecb = conv(hf(l, x, 1, w, seed), d10); ecr = conv(hf(l, x, 2, w, seed), d10);
      end else if (l % 2 == 1) begin
         tg = "R4"; ecv = (x % 2 == 0);
         ecb = conv((hf(l-1, x, 1, w, seed) + hf(l, x, 1, w, seed) + 1) >> 1, d10);
         ecr = conv((hf(l-1, x, 2, w, seed) + hf(l, x, 2, w, seed) + 1) >> 1, d10);
      end else begin
         tg = (l == h - 1) ? "R5" : "R4";
         ecv = (x % 2 == 0) && (l == h - 1);
         ecb = conv(hf(l, x, 1, w, seed), d10); ecr = conv(hf(l, x, 2, w, seed), d10);
      end
      if (!d10 && en) tg = {tg, "/R7"};
      checks++;
      if (out_cvalid != ecv || (ecv && (out_cb != DW'(ecb) || out_cr != DW'(ecr)))) begin
         errors++;
         $display("FAIL %s chroma l=%0d x=%0d got cv=%0b cb=%0d cr=%0d exp cv=%0b cb=%0d cr=%0d",
                  tg, l, x, out_cvalid, out_cb, out_cr, ecv, ecb, ecr);
      end
   endtask

   task automatic run_frame(bit en, int lay, bit d10, int w, int h, int seed);
      int n, ii, oo, cyc;
      bit pending, stalled;
      logic [DW-1:0] sy, scb;
      logic scv;
      n = w * h; ii = 0; oo = 0; cyc = 0; pending = 0; stalled = 0;
      sy = '0; scb = '0; scv = 1'b0;
      @(negedge clk);
      cfg_en = en; cfg_layout = 2'(lay); cfg_depth10 = d10;
      cfg_width = WW'(w); cfg_height = HW'(h);
      while (oo < n) begin
         @(negedge clk);
         cyc++;
         if (!pending && ii < n && ((cyc + seed) % 5) != 3) pending = 1;
         in_valid  = pending;
         in_sof    = pending && (ii == 0);
         in_y      = DW'(pix(ii / w, ii % w, 0, seed));
         in_cb     = DW'(pix(ii / w, ii % w, 1, seed));
         in_cr     = DW'(pix(ii / w, ii % w, 2, seed));
         out_ready = ((cyc * 3 + seed) % 4) != 0;
         #1;
         if (stalled) begin  // R10: a stalled beat must not change
            checks++;
            if (!out_valid || out_y != sy || out_cb != scb || out_cvalid != scv) begin
               errors++;
               $display("FAIL R10 stall beat %0d got v=%0b y=%0d cb=%0d cv=%0b exp v=1 y=%0d cb=%0d cv=%0b",
                        oo, out_valid, out_y, out_cb, out_cvalid, sy, scb, scv);
            end
         end
         stalled = out_valid && !out_ready;
         sy = out_y; scb = out_cb; scv = out_cvalid;
         if (out_valid && out_ready) begin
            check_beat(en, lay, d10, w, h, seed, oo / w, oo % w);
            oo++;
         end
         if (in_valid && in_ready) begin
            ii++;
            pending = 0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int widths[4];
      widths = '{1, 2, 5, 6};
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin  // R1
         errors++;
         $display("FAIL R1 reset state got out_valid=%0b in_ready=%0b exp 0 1", out_valid, in_ready);
      end
      for (int lay = 0; lay < 4; lay++)
         for (int d = 0; d < 2; d++)
            for (int wi = 0; wi < 4; wi++)
               for (int h = 1; h <= 3; h++)
                  run_frame(1'b1, lay, d[0], widths[wi], h, lay*7 + wi*3 + h + d);
      run_frame(1'b1, 2, 1'b1, 9, 4, 5);   // R4 longer 4:2:0 frame
      run_frame(1'b1, 2, 1'b0, 7, 5, 2);   // R5 odd height, 8-bit
      run_frame(1'b0, 2, 1'b0, 5, 2, 4);   // R8 bypass ignores layout and depth
      run_frame(1'b0, 1, 1'b1, 6, 3, 9);   // R8 bypass
      run_frame(1'b1, 1, 1'b1, 6, 2, 1);   // R3 after bypass
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule